// File: doc/BRIEF.md
# Flash ECC Programming Policy Controller

This block sits between a command port and a small on-chip storage array laid out like flash memory. It enforces an ECC policy selected by a two-bit mode input. The modes are ECC off, ECC always on, and ECC per location. The array is organised as 128-bit quad words. Each quad word holds its data, eight Hamming check bits, one overall parity bit, and a flag that records whether ECC is in use for it.

Commands arrive over a valid/ready handshake. Each command carries a two-bit opcode, a byte address and 128 bits of write data. The four commands are:

- read a quad word;
- program one 32-bit word;
- program one quad word;
- program a full row as a burst of quad-word beats.

The policy logic rejects commands that the current mode forbids, and commands whose address is not aligned. Quad and row programming store fresh check bits and set the location's flag. Single-word programming patches 32 bits, leaves the check bits untouched and clears the flag.

On a read, single-error correction and double-error detection are applied only when the mode and the flag call for it. When a single bit is corrected, the block raises a one-cycle correction pulse. When an error cannot be corrected, the block raises a detection pulse and returns the stored data unchanged.

Top module: `flash_ecc_ctrl`

## Requirements
- R1: After reset, `cmd_ready` is 1 and `rsp_done` is 0. Every quad word reads as all zeros with no error pulse in every mode, and every ECC-use flag is cleared.
- R2: Opcodes are 0 for read, 1 for word program, 2 for quad program and 3 for row program. Any non-row command accepted while idle gets `rsp_done` high for one cycle, one cycle after acceptance. `rsp_code` is 0 for ok, 1 for illegal in the current mode and 2 for misaligned.
- R3: Mode values are 0 = ECC off, 1 = ECC always on and 2 = per-location ECC. In mode 1, a word program returns code 1 and changes nothing, even when it is also misaligned.
- R4: A word program with address bits [1:0] not zero returns code 2. A quad program with address bits [3:0] not zero returns code 2. A row program whose address is not aligned to a row (64 bytes by default) returns code 2. None of these writes the array, and reads ignore address bits [3:0].
- R5: In mode 0, reads return the stored data as is and never raise `rsp_sec` or `rsp_ded`.
- R6: A word program replaces bits [32*k+31:32*k] of the quad word, where k is address bits [3:2], with `cmd_wdata[31:0]`. It clears that quad word's flag, so a mode 2 read of it returns the raw data without correction.
- R7: Quad and row programs store check bits and set the flag in any mode. A mode 2 read of such a location is corrected.
- R8: In mode 1, every read applies correction, whatever the location's flag.
- R9: When a corrected read finds a single flipped data bit, it returns the original data with `rsp_sec` high for the response cycle only.
- R10: When a corrected read finds two flipped bits, it returns the stored (uncorrected) data with `rsp_ded` high and `rsp_sec` low. The two error pulses are never high together.
- R11: A legal row program accepts ROW_QW beats and writes successive quad words from the row start. `cmd_ready` stays high between beats. Opcode and address are ignored after the first beat, and `rsp_done` comes only one cycle after the last beat.
- R12: Mode value 3 behaves exactly like mode 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ecc_mode | input | 2 | ECC policy, sampled when a command is accepted |
| cmd_valid | input | 1 | Command or row beat present |
| cmd_ready | output | 1 | Command can be accepted |
| cmd_op | input | 2 | Opcode |
| cmd_addr | input | ADDR_W | Byte address |
| cmd_wdata | input | 128 | Program data (word program uses bits [31:0]) |
| rsp_done | output | 1 | Response strobe |
| rsp_code | output | 2 | Response status |
| rsp_rdata | output | 128 | Read data, held until the next read |
| rsp_sec | output | 1 | Single error corrected |
| rsp_ded | output | 1 | Uncorrectable error detected |

## Verification
Several rules hold on every cycle and are checked there:

- a response always follows an accepted command;
- the two error pulses never coincide and appear only with an ok response;
- a rejected command never produces a write strobe;
- a word program in mode 1 always answers illegal;
- mode 0 reads never flag errors;
- the port stays ready during a row burst.

Other behaviour can only be shown by the bench scenarios. Corrupting a quad word through a word program in mode 0, then reading it in each mode, shows three things: correction of every one of the 128 data-bit positions, double-error detection, and the way the flag changes what a mode 2 read returns. The same scenarios cover row beat ordering and the fact that rejected commands leave the data untouched.

// File: rtl/fecc_pkg.sv
// Shared types and code-construction helpers for the flash ECC controller.
// Assumes a 128-bit quad word protected by an extended Hamming code:
// 8 check bits at power-of-two positions plus one overall parity bit.
package fecc_pkg;

    localparam int QW_BITS   = 128;
    localparam int WORD_BITS = 32;
    localparam int CHK_BITS  = 8;
    localparam int POS_LIMIT = 1 << CHK_BITS;

    typedef enum logic [1:0] {
        EM_OFF    = 2'd0,
        EM_ON     = 2'd1,
        EM_DYN    = 2'd2,
        EM_ON_ALT = 2'd3
    } ecc_mode_e;

    typedef enum logic [1:0] {
        OP_READ = 2'd0,
        OP_WORD = 2'd1,
        OP_QUAD = 2'd2,
        OP_ROW  = 2'd3
    } cmd_op_e;

    typedef enum logic [1:0] {
        RC_OK       = 2'd0,
        RC_ILLEGAL  = 2'd1,
        RC_MISALIGN = 2'd2,
        RC_RSVD     = 2'd3
    } rsp_code_e;

    // Set of data bits covered by check bit j.
    function automatic logic [QW_BITS-1:0] chk_mask(input int j);
        logic [QW_BITS-1:0] m;
        int d;
        m = '0;
        d = 0;
        for (int p = 1; p < POS_LIMIT; p++) begin
            if (((p & (p - 1)) != 0) && (d < QW_BITS)) begin
                if (((p >> j) & 1) == 1) m[d] = 1'b1;
                d++;
            end
        end
        return m;
    endfunction

    // Codeword position (1-based) occupied by data bit i.
    function automatic logic [CHK_BITS-1:0] data_pos(input int i);
        logic [CHK_BITS-1:0] r;
        int d;
        r = '0;
        d = 0;
        for (int p = 1; p < POS_LIMIT; p++) begin
            if ((p & (p - 1)) != 0) begin
                if (d == i) r = CHK_BITS'(p);
                d++;
            end
        end
        return r;
    endfunction

endpackage

// File: rtl/fecc_codec.sv
// SEC-DED encoder and decoder for one quad word.
// The encoder is purely combinational over the program data. The decoder
// takes a stored codeword and an apply flag. With apply low, it passes the
// data through and raises no error.
// Assumes the construction helpers in fecc_pkg.
module fecc_codec
    import fecc_pkg::*;
(
    input  logic [QW_BITS-1:0]  enc_data,
    output logic [CHK_BITS-1:0] enc_chk,
    output logic                enc_par,
    input  logic [QW_BITS-1:0]  dec_data,
    input  logic [CHK_BITS-1:0] dec_chk,
    input  logic                dec_par,
    input  logic                dec_apply,
    output logic [QW_BITS-1:0]  dec_out,
    output logic                dec_sec,
    output logic                dec_ded
);

    localparam logic [CHK_BITS-1:0] MAX_POS = data_pos(QW_BITS - 1);

    logic [CHK_BITS-1:0] re_chk;
    logic [CHK_BITS-1:0] syn;
    logic [QW_BITS-1:0]  flip;
    logic                odd;

    // One check bit per parity group, both for encode and for re-check.
    for (genvar j = 0; j < CHK_BITS; j++) begin : g_chk
        localparam logic [QW_BITS-1:0] MASK = chk_mask(j);
        assign enc_chk[j] = ^(enc_data & MASK);
        assign re_chk[j]  = ^(dec_data & MASK);
    end

    // Overall parity over data and check bits.
    assign enc_par = (^enc_data) ^ (^enc_chk);

    assign syn = dec_chk ^ re_chk;
    assign odd = (^dec_data) ^ (^dec_chk) ^ dec_par;

    // Flip a data bit when the syndrome points at its position.
    for (genvar i = 0; i < QW_BITS; i++) begin : g_fix
        localparam logic [CHK_BITS-1:0] POS = data_pos(i);
        assign flip[i] = dec_apply && odd && (syn == POS);
    end

    assign dec_out = dec_data ^ flip;

    // Classify the error: odd parity with a valid position is correctable.
    always_comb begin
        dec_sec = 1'b0;
        dec_ded = 1'b0;
        if (dec_apply) begin
            if (odd && (syn <= MAX_POS)) begin
                dec_sec = 1'b1;
            end else if (odd || (syn != '0)) begin
                dec_ded = 1'b1;
            end
        end
    end

endmodule

// File: rtl/fecc_policy.sv
// Command legality and read-correction policy.
// Purely combinational. Decides the response code from mode, opcode and
// low address bits, and whether a read should be corrected.
// Assumes ROW_SH >= 4, so a row is at least one quad word.
module fecc_policy
    import fecc_pkg::*;
#(
    parameter int ROW_SH = 6
) (
    input  logic [1:0]        mode,
    input  logic [1:0]        op,
    input  logic [ROW_SH-1:0] addr_lo,
    input  logic              flag,
    output logic [1:0]        code,
    output logic              read_apply
);

    logic mode_on;
    logic mode_dyn;

    assign mode_on  = (mode == EM_ON) || (mode == EM_ON_ALT);
    assign mode_dyn = (mode == EM_DYN);

    // Legality: the mode check outranks alignment.
    always_comb begin
        code = RC_OK;
        case (cmd_op_e'(op))
            OP_WORD: begin
                if (mode_on)                  code = RC_ILLEGAL;
                else if (addr_lo[1:0] != '0)  code = RC_MISALIGN;
            end
            OP_QUAD: begin
                if (addr_lo[3:0] != '0)       code = RC_MISALIGN;
            end
            OP_ROW: begin
                if (addr_lo != '0)            code = RC_MISALIGN;
            end
            default: code = RC_OK;
        endcase
    end

    // Correction on read: always in the on modes, per flag in dynamic mode.
    assign read_apply = mode_on || (mode_dyn && flag);

endmodule

// File: rtl/fecc_store.sv
// Quad-word storage with check bits, parity and an ECC-use flag.
// One write port (full quad or one 32-bit word) and one asynchronous
// read port. Reset clears data, check bits and flags. All zeros is a
// valid codeword.
module fecc_store
    import fecc_pkg::*;
#(
    parameter int NUM_QW = 16,
    parameter int IDX_W  = $clog2(NUM_QW)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                we_quad,
    input  logic                we_word,
    input  logic [IDX_W-1:0]    widx,
    input  logic [1:0]          wsel,
    input  logic [QW_BITS-1:0]  wdata,
    input  logic [CHK_BITS-1:0] wchk,
    input  logic                wpar,
    input  logic [IDX_W-1:0]    ridx,
    output logic [QW_BITS-1:0]  rdata,
    output logic [CHK_BITS-1:0] rchk,
    output logic                rpar,
    output logic                rflag
);

    logic [QW_BITS-1:0]  arr_d [NUM_QW];
    logic [CHK_BITS-1:0] arr_c [NUM_QW];
    logic                arr_p [NUM_QW];
    logic                arr_f [NUM_QW];

    for (genvar q = 0; q < NUM_QW; q++) begin : g_qw
        logic [QW_BITS-1:0]  d_q;
        logic [CHK_BITS-1:0] c_q;
        logic                p_q;
        logic                f_q;
        logic                hit;

        assign hit = (widx == IDX_W'(q));

        // Per-entry update: a full quad write sets the flag, a word patch clears it.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                d_q <= '0;
                c_q <= '0;
                p_q <= 1'b0;
                f_q <= 1'b0;
            end else if (we_quad && hit) begin
                d_q <= wdata;
                c_q <= wchk;
                p_q <= wpar;
                f_q <= 1'b1;
            end else if (we_word && hit) begin
                d_q[wsel*WORD_BITS +: WORD_BITS] <= wdata[WORD_BITS-1:0];
                f_q <= 1'b0;
            end
        end

        assign arr_d[q] = d_q;
        assign arr_c[q] = c_q;
        assign arr_p[q] = p_q;
        assign arr_f[q] = f_q;
    end

    assign rdata = arr_d[ridx];
    assign rchk  = arr_c[ridx];
    assign rpar  = arr_p[ridx];
    assign rflag = arr_f[ridx];

endmodule

// File: rtl/flash_ecc_ctrl.sv
// Flash ECC programming policy controller (top).
// Accepts read, word, quad and row commands over valid/ready, applies the
// mode policy, programs the storage with check bits, and corrects reads.
// Assumes NUM_QW is a power of two and a multiple of ROW_QW, and ROW_QW is
// a power of two. The mode is sampled when a command is accepted.
module flash_ecc_ctrl
    import fecc_pkg::*;
#(
    parameter int NUM_QW = 16,
    parameter int ROW_QW = 4,
    parameter int ADDR_W = $clog2(NUM_QW) + 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        ecc_mode,
    input  logic              cmd_valid,
    output logic              cmd_ready,
    input  logic [1:0]        cmd_op,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic [127:0]      cmd_wdata,
    output logic              rsp_done,
    output logic [1:0]        rsp_code,
    output logic [127:0]      rsp_rdata,
    output logic              rsp_sec,
    output logic              rsp_ded
);

    localparam int IDX_W  = $clog2(NUM_QW);
    localparam int ROW_SH = $clog2(ROW_QW) + 4;
    localparam int ROW_CW = (ROW_QW > 1) ? $clog2(ROW_QW) : 1;
    localparam logic [ROW_CW-1:0] ROW_LAST = ROW_CW'(ROW_QW - 1);
    localparam bit MULTI_BEAT = (ROW_QW > 1);

    logic              live_q;
    logic              acc;
    logic              idle_acc;
    logic              row_busy;
    logic [ROW_CW-1:0] row_cnt;
    logic [IDX_W-1:0]  row_idx;
    logic [IDX_W-1:0]  cmd_idx;
    logic [1:0]        pol_code;
    logic              pol_apply;
    logic              pol_ok;
    logic              we_quad;
    logic              we_word;
    logic              store_we;
    logic [IDX_W-1:0]  widx;
    logic [CHK_BITS-1:0] enc_chk;
    logic                enc_par;
    logic [QW_BITS-1:0]  st_data;
    logic [CHK_BITS-1:0] st_chk;
    logic                st_par;
    logic                st_flag;
    logic [QW_BITS-1:0]  dec_out;
    logic                dec_sec;
    logic                dec_ded;
    logic                is_read;
    logic                is_row;
    logic                row_last_beat;

    assign cmd_ready     = live_q;
    assign acc           = cmd_valid && cmd_ready;
    assign idle_acc      = acc && !row_busy;
    assign cmd_idx       = cmd_addr[ADDR_W-1:4];
    assign pol_ok        = (pol_code == RC_OK);
    assign is_read       = (cmd_op == OP_READ);
    assign is_row        = (cmd_op == OP_ROW);
    assign row_last_beat = acc && row_busy && (row_cnt == ROW_LAST);

    fecc_policy #(
        .ROW_SH(ROW_SH)
    ) u_policy (
        .mode       (ecc_mode),
        .op         (cmd_op),
        .addr_lo    (cmd_addr[ROW_SH-1:0]),
        .flag       (st_flag),
        .code       (pol_code),
        .read_apply (pol_apply)
    );

    // Write strobes: legal quad/row first beat, every later row beat, legal word patch.
    assign we_quad  = (idle_acc && pol_ok && ((cmd_op == OP_QUAD) || is_row)) ||
                      (acc && row_busy);
    assign we_word  = idle_acc && pol_ok && (cmd_op == OP_WORD);
    assign store_we = we_quad || we_word;
    assign widx     = row_busy ? row_idx : cmd_idx;

    fecc_store #(
        .NUM_QW(NUM_QW),
        .IDX_W (IDX_W)
    ) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .we_quad (we_quad),
        .we_word (we_word),
        .widx    (widx),
        .wsel    (cmd_addr[3:2]),
        .wdata   (cmd_wdata),
        .wchk    (enc_chk),
        .wpar    (enc_par),
        .ridx    (cmd_idx),
        .rdata   (st_data),
        .rchk    (st_chk),
        .rpar    (st_par),
        .rflag   (st_flag)
    );

    fecc_codec u_codec (
        .enc_data  (cmd_wdata),
        .enc_chk   (enc_chk),
        .enc_par   (enc_par),
        .dec_data  (st_data),
        .dec_chk   (st_chk),
        .dec_par   (st_par),
        .dec_apply (pol_apply),
        .dec_out   (dec_out),
        .dec_sec   (dec_sec),
        .dec_ded   (dec_ded)
    );

    // Out-of-reset marker that gates the ready output.
    always_ff @(posedge clk) begin
        if (!rst_n) live_q <= 1'b0;
        else        live_q <= 1'b1;
    end

    // Row burst tracking: beat count and next quad-word index.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            row_busy <= 1'b0;
            row_cnt  <= '0;
            row_idx  <= '0;
        end else if (idle_acc && pol_ok && is_row && MULTI_BEAT) begin
            row_busy <= 1'b1;
            row_cnt  <= ROW_CW'(1);
            row_idx  <= cmd_idx + IDX_W'(1);
        end else if (acc && row_busy) begin
            row_busy <= !row_last_beat;
            row_cnt  <= row_cnt + ROW_CW'(1);
            row_idx  <= row_idx + IDX_W'(1);
        end
    end

    // Response strobe, status and error pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_done <= 1'b0;
            rsp_code <= RC_OK;
            rsp_sec  <= 1'b0;
            rsp_ded  <= 1'b0;
        end else begin
            rsp_done <= (idle_acc && !(is_row && pol_ok && MULTI_BEAT)) || row_last_beat;
            rsp_code <= idle_acc ? pol_code : RC_OK;
            rsp_sec  <= idle_acc && is_read && dec_sec;
            rsp_ded  <= idle_acc && is_read && dec_ded;
        end
    end

    // Read data register, updated only by reads.
    always_ff @(posedge clk) begin
        if (!rst_n)                   rsp_rdata <= '0;
        else if (idle_acc && is_read) rsp_rdata <= dec_out;
    end

endmodule

// File: rtl/fecc_ctrl_chk.sv
// Cycle-level checks on the controller's handshake, policy and error pulses.
// Attached to every flash_ecc_ctrl instance through the bind below.
module fecc_ctrl_chk
    import fecc_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic [1:0] ecc_mode,
    input logic       cmd_valid,
    input logic       cmd_ready,
    input logic [1:0] cmd_op,
    input logic       rsp_done,
    input logic [1:0] rsp_code,
    input logic       rsp_sec,
    input logic       rsp_ded,
    input logic       row_busy,
    input logic       store_we
);

    AST_DONE_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |-> $past(cmd_valid && cmd_ready)); // R2

    AST_WORD_ILLEGAL_ON: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_ready && !row_busy && cmd_op == OP_WORD && ecc_mode == EM_ON)
        |=> (rsp_done && rsp_code == RC_ILLEGAL)); // R3

    AST_REJECT_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_done && rsp_code != RC_OK) |-> $past(!store_we)); // R4

    AST_OFF_NO_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_ready && !row_busy && cmd_op == OP_READ && ecc_mode == EM_OFF)
        |=> (!rsp_sec && !rsp_ded)); // R5

    AST_ERR_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_sec || rsp_ded) |-> (rsp_done && rsp_code == RC_OK)); // R9

    AST_ERR_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({rsp_sec, rsp_ded})); // R10

    AST_ROW_READY: assert property (@(posedge clk) disable iff (!rst_n)
        row_busy |-> cmd_ready); // R11

endmodule

bind flash_ecc_ctrl fecc_ctrl_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ecc_mode  (ecc_mode),
    .cmd_valid (cmd_valid),
    .cmd_ready (cmd_ready),
    .cmd_op    (cmd_op),
    .rsp_done  (rsp_done),
    .rsp_code  (rsp_code),
    .rsp_sec   (rsp_sec),
    .rsp_ded   (rsp_ded),
    .row_busy  (row_busy),
    .store_we  (store_we)
);

// File: tb/flash_ecc_ctrl_bench.sv
`timescale 1ns/1ps
module flash_ecc_ctrl_bench;

    localparam int NQ = 16;
    localparam int RQ = 4;
    localparam int AW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [1:0]    ecc_mode = 2'd0;
    logic          cmd_valid = 1'b0;
    logic          cmd_ready;
    logic [1:0]    cmd_op = 2'd0;
    logic [AW-1:0] cmd_addr = '0;
    logic [127:0]  cmd_wdata = '0;
    logic          rsp_done;
    logic [1:0]    rsp_code;
    logic [127:0]  rsp_rdata;
    logic          rsp_sec;
    logic          rsp_ded;

    int total = 0;
    int bad = 0;

    logic         g_done;
    logic [1:0]   g_code;
    logic [127:0] g_data;
    logic         g_sec;
    logic         g_ded;

    always #10 clk = ~clk;

    flash_ecc_ctrl u_flash_ecc_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .ecc_mode  (ecc_mode),
        .cmd_valid (cmd_valid),
        .cmd_ready (cmd_ready),
        .cmd_op    (cmd_op),
        .cmd_addr  (cmd_addr),
        .cmd_wdata (cmd_wdata),
        .rsp_done  (rsp_done),
        .rsp_code  (rsp_code),
        .rsp_rdata (rsp_rdata),
        .rsp_sec   (rsp_sec),
        .rsp_ded   (rsp_ded)
    );

    task automatic check(input string tag, input logic [127:0] act, input logic [127:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    function automatic logic [127:0] pat(input int q, input int s);
        logic [127:0] r;
        for (int w = 0; w < 4; w++)
            r[w*32 +: 32] = 32'(((q * 4 + w + 1) * 32'h9E3779B9) ^ (s * 32'h01000193));
        return r;
    endfunction

    // One command: drive at a falling edge, sample at the next one.
    task automatic cmd(input logic [1:0] m, input logic [1:0] op,
                       input logic [AW-1:0] a, input logic [127:0] d);
        @(negedge clk);
        ecc_mode  = m;
        cmd_valid = 1'b1;
        cmd_op    = op;
        cmd_addr  = a;
        cmd_wdata = d;
        @(negedge clk);
        cmd_valid = 1'b0;
        g_done = rsp_done;
        g_code = rsp_code;
        g_data = rsp_rdata;
        g_sec  = rsp_sec;
        g_ded  = rsp_ded;
    endtask

    task automatic run(input string tag, input logic [1:0] m, input logic [1:0] op,
                       input logic [AW-1:0] a, input logic [127:0] d, input logic [1:0] code);
        cmd(m, op, a, d);
        check({tag, " R2 done"}, 128'(g_done), 128'(1));
        check({tag, " code"}, 128'(g_code), 128'(code));
    endtask

    task automatic rd(input string tag, input logic [1:0] m, input logic [AW-1:0] a,
                      input logic [127:0] exp, input logic es, input logic ed);
        cmd(m, 2'd0, a, '0);
        check({tag, " R2 done"}, 128'(g_done), 128'(1));
        check({tag, " data"}, g_data, exp);
        check({tag, " sec"}, 128'(g_sec), 128'(es));
        check({tag, " ded"}, 128'(g_ded), 128'(ed));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [127:0] o;
        logic [127:0] f;
        logic [127:0] rowv [RQ];
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 ready", 128'(cmd_ready), 128'(1));
        check("R1 done idle", 128'(rsp_done), 128'(0));
        for (int q = 0; q < NQ; q++) begin
            rd("R1 reset dyn", 2'd2, AW'(q * 16), '0, 1'b0, 1'b0);
            rd("R1 reset on", 2'd1, AW'(q * 16 + 5), '0, 1'b0, 1'b0);
        end

        // R3: word program forbidden in always-on mode, plus priority over alignment
        run("R3 word on", 2'd1, 2'd1, 8'h20, 128'hDEADBEEF, 2'd1);
        run("R3 word on misaligned", 2'd1, 2'd1, 8'h51, 128'h1234, 2'd1);
        run("R12 word mode3", 2'd3, 2'd1, 8'h24, 128'h5555, 2'd1);
        rd("R3 unchanged", 2'd0, 8'h20, '0, 1'b0, 1'b0);

        // R4: misalignment sweep
        for (int lo = 1; lo < 16; lo++)
            run("R4 quad misaligned", 2'd2, 2'd2, AW'(8'h30 + lo), pat(3, lo), 2'd2);
        rd("R4 quad untouched", 2'd0, 8'h30, '0, 1'b0, 1'b0);
        for (int lo = 1; lo < 4; lo++)
            run("R4 word misaligned", 2'd2, 2'd1, AW'(8'h50 + lo), 128'hFFFF, 2'd2);
        rd("R4 word untouched", 2'd0, 8'h50, '0, 1'b0, 1'b0);
        run("R4 row at 0x10", 2'd2, 2'd3, 8'h10, pat(1, 0), 2'd2);
        run("R4 row at 0x48", 2'd2, 2'd3, 8'h48, pat(4, 0), 2'd2);
        rd("R4 row untouched", 2'd0, 8'h10, '0, 1'b0, 1'b0);
        rd("R4 row untouched b", 2'd0, 8'h40, '0, 1'b0, 1'b0);

        // R11: row burst at 0x40, later beats carry read opcode and a junk address
        for (int b = 0; b < RQ; b++) rowv[b] = pat(4 + b, 77);
        for (int b = 0; b < RQ; b++) begin
            @(negedge clk);
            if (b > 0) begin
                check("R11 no early done", 128'(rsp_done), 128'(0));
                check("R11 ready in burst", 128'(cmd_ready), 128'(1));
            end
            ecc_mode  = 2'd2;
            cmd_valid = 1'b1;
            cmd_op    = (b == 0) ? 2'd3 : 2'd0;
            cmd_addr  = (b == 0) ? 8'h40 : 8'h03;
            cmd_wdata = rowv[b];
        end
        @(negedge clk);
        cmd_valid = 1'b0;
        check("R11 done after last", 128'(rsp_done), 128'(1));
        check("R11 code", 128'(rsp_code), 128'(0));
        for (int b = 0; b < RQ; b++) rd("R11 row data", 2'd2, AW'(8'h40 + b * 16), rowv[b], 1'b0, 1'b0);
        rd("R11 qw0 untouched", 2'd0, 8'h00, '0, 1'b0, 1'b0);

        // R7: a quad program in mode 0 still stores check bits and sets the flag
        run("R7 quad off", 2'd0, 2'd2, 8'h80, pat(8, 1), 2'd0);
        rd("R7 dyn read", 2'd2, 8'h8C, pat(8, 1), 1'b0, 1'b0);

        // Single-bit sweep over all 128 data bits
        for (int b = 0; b < 128; b++) begin
            int q;
            int w;
            q = b % NQ;
            w = b / 32;
            o = pat(q, b);
            f = o ^ (128'd1 << b);
            run("R7 quad dyn", 2'd2, 2'd2, AW'(q * 16), o, 2'd0);
            rd("R7 dyn clean", 2'd2, AW'(q * 16), o, 1'b0, 1'b0);
            run("R6 word off", 2'd0, 2'd1, AW'(q * 16 + w * 4), 128'(f[w*32 +: 32]), 2'd0);
            rd("R5 off raw", 2'd0, AW'(q * 16), f, 1'b0, 1'b0);
            rd("R6 dyn raw", 2'd2, AW'(q * 16), f, 1'b0, 1'b0);
            rd("R8 R9 on corrected", 2'd1, AW'(q * 16), o, 1'b1, 1'b0);
            rd("R12 mode3 corrected", 2'd3, AW'(q * 16), o, 1'b1, 1'b0);
        end

        // R10: double errors across two words
        for (int b = 0; b < 95; b += 7) begin
            int b2;
            b2 = b + 33;
            o = pat(9, b);
            f = o ^ (128'd1 << b) ^ (128'd1 << b2);
            run("R10 quad", 2'd2, 2'd2, 8'h90, o, 2'd0);
            run("R10 word a", 2'd0, 2'd1, AW'(8'h90 + (b / 32) * 4), 128'(f[(b/32)*32 +: 32]), 2'd0);
            run("R10 word b", 2'd0, 2'd1, AW'(8'h90 + (b2 / 32) * 4), 128'(f[(b2/32)*32 +: 32]), 2'd0);
            rd("R10 on detect", 2'd1, 8'h90, f, 1'b0, 1'b1);
            rd("R10 off raw", 2'd0, 8'h90, f, 1'b0, 1'b0);
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule